// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block computes the data-memory effective addresses for the operand-moving class of instructions in a 16-bit register-file processor. Each instruction has two address paths, source and destination, and each path picks its own addressing mode. For each path the block takes the decoded mode, the number and current value of the base register, and the byte/word size flag. Both paths share one offset-register value and one signed literal.

For each path the block returns an effective address and a flag that marks the operand as living in a register rather than in memory. When the mode modifies the base register, it also returns a write-back request carrying the register number and its new value. The results are registered. They appear, together with an output-valid strobe, in the cycle after the request. The register file applies the write-back in that same cycle.

Top module: `agu_ea_gen`

## Requirements
- R1: While rst_ni is low, every output is zero.
- R2: out_valid_o is high in exactly the cycle after a cycle with req_i high. When out_valid_o is low, all address, flag and write-back outputs are zero.
- R3: Mode code 0 (register direct) raises the path's register-operand flag, gives address 0 and requests no write-back.
- R4: Mode code 1 (indirect) gives the base value as the address, with no write-back.
- R5: Mode codes 2 (post-decrement) and 3 (post-increment) give the original base value as the address. They request a write-back of base minus or plus the step to the path's base register number.
- R6: Mode codes 4 (pre-decrement) and 5 (pre-increment) compute base minus or plus the step. They use that value both as the address and as the write-back value.
- R7: The step is 1 when byte_i is 1 and 2 when byte_i is 0.
- R8: Mode code 6 (indexed) gives base plus the shared offset value as the address, with no write-back. Both paths add the same offset value.
- R9: Mode code 7 (literal offset) gives base plus the LW-bit literal, sign-extended, as the address, with no write-back.
- R10: Source and destination paths use independent modes, bases and register numbers in the same cycle.
- R11: All address arithmetic wraps modulo 2^DW.
- R12: A write-back request is never raised unless out_valid_o is high, and write-back number and value are zero when no write-back is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Compute addresses for the presented operands |
| byte_i | input | 1 | 1 = byte access, 0 = word access |
| ofs_i | input | DW | Value of the shared offset register |
| lit_i | input | LW | Signed literal offset |
| src_mode_i | input | 3 | Source addressing mode code |
| src_num_i | input | RW | Source base register number |
| src_base_i | input | DW | Source base register value |
| dst_mode_i | input | 3 | Destination addressing mode code |
| dst_num_i | input | RW | Destination base register number |
| dst_base_i | input | DW | Destination base register value |
| out_valid_o | output | 1 | Results valid this cycle |
| src_ea_o | output | DW | Source effective address |
| src_reg_o | output | 1 | Source operand is a register |
| src_wb_en_o | output | 1 | Source base write-back request |
| src_wb_num_o | output | RW | Source write-back register number |
| src_wb_val_o | output | DW | Source write-back value |
| dst_ea_o | output | DW | Destination effective address |
| dst_reg_o | output | 1 | Destination operand is a register |
| dst_wb_en_o | output | 1 | Destination base write-back request |
| dst_wb_num_o | output | RW | Destination write-back register number |
| dst_wb_val_o | output | DW | Destination write-back value |

## Verification
The assertions check the behaviour that holds on every cycle. These are the one-cycle request-to-valid timing, the zeroed outputs when idle, the link between write-back and valid, and the address and write-back relations of the direct, post-modify, pre-modify and indexed modes on the source path. Only the bench scenarios show that the literal offset is sign-extended and that address arithmetic wraps at the top and bottom of the address space. They also show that the destination path works alongside a different source mode, and that an asynchronous reset in mid-run clears a pending result.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    AM_REG      = 3'd0,
    AM_IND      = 3'd1,
    AM_POST_DEC = 3'd2,
    AM_POST_INC = 3'd3,
    AM_PRE_DEC  = 3'd4,
    AM_PRE_INC  = 3'd5,
    AM_IDX      = 3'd6,
    AM_LIT      = 3'd7
  } am_e;
endpackage

// File: rtl/agu_mod_unit.sv
module agu_mod_unit #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] base_i,
  input  logic          byte_i,
  input  logic          dec_i,
  output logic [DW-1:0] val_o
);
  logic [DW-1:0] step;

  assign step  = {{(DW-2){1'b0}}, ~byte_i, byte_i};
  assign val_o = dec_i ? base_i - step : base_i + step;
endmodule

// File: rtl/agu_path.sv
module agu_path
  import agu_pkg::*;
#(
  parameter int DW = 16,
  parameter int RW = 4,
  parameter int LW = 10
) (
  input  logic [2:0]    mode_i,
  input  logic [RW-1:0] num_i,
  input  logic [DW-1:0] base_i,
  input  logic [DW-1:0] ofs_i,
  input  logic [LW-1:0] lit_i,
  input  logic          byte_i,
  output logic [DW-1:0] ea_o,
  output logic          reg_o,
  output logic          wb_en_o,
  output logic [RW-1:0] wb_num_o,
  output logic [DW-1:0] wb_val_o
);
  am_e           mode;
  logic          dec;
  logic [DW-1:0] modv;
  logic [DW-1:0] lit_x;

  assign mode  = am_e'(mode_i);
  assign dec   = (mode == AM_POST_DEC) || (mode == AM_PRE_DEC);
  assign lit_x = {{(DW-LW){lit_i[LW-1]}}, lit_i};

  agu_mod_unit #(.DW(DW)) u_mod (
    .base_i (base_i),
    .byte_i (byte_i),
    .dec_i  (dec),
    .val_o  (modv)
  );

  always_comb begin
    ea_o     = '0;
    reg_o    = 1'b0;
    wb_en_o  = 1'b0;
    wb_num_o = '0;
    wb_val_o = '0;
    unique case (mode)
      AM_REG: reg_o = 1'b1;
      AM_IND: ea_o  = base_i;
      AM_POST_DEC, AM_POST_INC: begin
        ea_o     = base_i;
        wb_en_o  = 1'b1;
        wb_num_o = num_i;
        wb_val_o = modv;
      end
      AM_PRE_DEC, AM_PRE_INC: begin
        ea_o     = modv;
        wb_en_o  = 1'b1;
        wb_num_o = num_i;
        wb_val_o = modv;
      end
      AM_IDX: ea_o = base_i + ofs_i;
      AM_LIT: ea_o = base_i + lit_x;
      default: ea_o = '0;
    endcase
  end
endmodule

// File: rtl/agu_stage.sv
module agu_stage #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= en_i ? d_i : '0;
  end
endmodule

// File: rtl/agu_ea_gen.sv
module agu_ea_gen #(
  parameter int DW = 16,
  parameter int RW = 4,
  parameter int LW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          byte_i,
  input  logic [DW-1:0] ofs_i,
  input  logic [LW-1:0] lit_i,
  input  logic [2:0]    src_mode_i,
  input  logic [RW-1:0] src_num_i,
  input  logic [DW-1:0] src_base_i,
  input  logic [2:0]    dst_mode_i,
  input  logic [RW-1:0] dst_num_i,
  input  logic [DW-1:0] dst_base_i,
  output logic          out_valid_o,
  output logic [DW-1:0] src_ea_o,
  output logic          src_reg_o,
  output logic          src_wb_en_o,
  output logic [RW-1:0] src_wb_num_o,
  output logic [DW-1:0] src_wb_val_o,
  output logic [DW-1:0] dst_ea_o,
  output logic          dst_reg_o,
  output logic          dst_wb_en_o,
  output logic [RW-1:0] dst_wb_num_o,
  output logic [DW-1:0] dst_wb_val_o
);
  localparam int NP = 2;
  localparam int PW = 2 * DW + RW + 2;

  logic [2:0]    mode_a [NP];
  logic [RW-1:0] num_a  [NP];
  logic [DW-1:0] base_a [NP];
  logic [PW-1:0] res_q  [NP];

  assign mode_a[0] = src_mode_i;
  assign mode_a[1] = dst_mode_i;
  assign num_a[0]  = src_num_i;
  assign num_a[1]  = dst_num_i;
  assign base_a[0] = src_base_i;
  assign base_a[1] = dst_base_i;

  for (genvar p = 0; p < NP; p++) begin : g_path
    logic [DW-1:0] ea;
    logic          is_reg;
    logic          wb_en;
    logic [RW-1:0] wb_num;
    logic [DW-1:0] wb_val;

    agu_path #(.DW(DW), .RW(RW), .LW(LW)) u_path (
      .mode_i   (mode_a[p]),
      .num_i    (num_a[p]),
      .base_i   (base_a[p]),
      .ofs_i    (ofs_i),
      .lit_i    (lit_i),
      .byte_i   (byte_i),
      .ea_o     (ea),
      .reg_o    (is_reg),
      .wb_en_o  (wb_en),
      .wb_num_o (wb_num),
      .wb_val_o (wb_val)
    );

    agu_stage #(.W(PW)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (req_i),
      .d_i    ({ea, is_reg, wb_en, wb_num, wb_val}),
      .q_o    (res_q[p])
    );
  end

  agu_stage #(.W(1)) u_vld (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (1'b1),
    .d_i    (req_i),
    .q_o    (out_valid_o)
  );

  assign {src_ea_o, src_reg_o, src_wb_en_o, src_wb_num_o, src_wb_val_o} = res_q[0];
  assign {dst_ea_o, dst_reg_o, dst_wb_en_o, dst_wb_num_o, dst_wb_val_o} = res_q[1];
endmodule

// File: rtl/agu_ea_gen_chk.sv
module agu_ea_gen_chk #(
  parameter int DW = 16,
  parameter int RW = 4,
  parameter int LW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          byte_i,
  input logic [DW-1:0] ofs_i,
  input logic [LW-1:0] lit_i,
  input logic [2:0]    src_mode_i,
  input logic [RW-1:0] src_num_i,
  input logic [DW-1:0] src_base_i,
  input logic [2:0]    dst_mode_i,
  input logic [RW-1:0] dst_num_i,
  input logic [DW-1:0] dst_base_i,
  input logic          out_valid_o,
  input logic [DW-1:0] src_ea_o,
  input logic          src_reg_o,
  input logic          src_wb_en_o,
  input logic [RW-1:0] src_wb_num_o,
  input logic [DW-1:0] src_wb_val_o,
  input logic [DW-1:0] dst_ea_o,
  input logic          dst_reg_o,
  input logic          dst_wb_en_o,
  input logic [RW-1:0] dst_wb_num_o,
  input logic [DW-1:0] dst_wb_val_o
);
  function automatic logic [DW-1:0] stp(input logic b);
    return b ? DW'(1) : DW'(2);
  endfunction

  p_req_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> out_valid_o);
  p_idle_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !out_valid_o);
  p_idle_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (src_ea_o == '0 && dst_ea_o == '0 && !src_reg_o && !dst_reg_o));
  p_wb_valid_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_wb_en_o || dst_wb_en_o) |-> out_valid_o);
  p_wb_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_wb_en_o |-> (src_wb_num_o == '0 && src_wb_val_o == '0));
  p_direct_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && src_mode_i == 3'd0) |=> (src_reg_o && !src_wb_en_o && src_ea_o == '0));
  p_post_inc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && src_mode_i == 3'd3) |=>
      (src_ea_o == $past(src_base_i) && src_wb_en_o && src_wb_num_o == $past(src_num_i)
       && src_wb_val_o == DW'($past(src_base_i) + stp($past(byte_i)))));
  p_post_dec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && src_mode_i == 3'd2) |=>
      (src_ea_o == $past(src_base_i) && src_wb_en_o
       && src_wb_val_o == DW'($past(src_base_i) - stp($past(byte_i)))));
  p_pre_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (src_mode_i == 3'd4 || src_mode_i == 3'd5)) |=>
      (src_wb_en_o && src_ea_o == src_wb_val_o && src_ea_o != $past(src_base_i)));
  p_idx_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && src_mode_i == 3'd6) |=>
      (!src_wb_en_o && src_ea_o == DW'($past(src_base_i) + $past(ofs_i))));
endmodule

bind agu_ea_gen agu_ea_gen_chk #(.DW(DW), .RW(RW), .LW(LW)) u_chk (.*);

// File: tb/sim_agu_ea_gen.sv
module sim_agu_ea_gen;
  localparam int DW = 16;
  localparam int RW = 4;
  localparam int LW = 10;
  localparam int NV = 10;

  typedef struct packed {
    logic [2:0]    sm;
    logic [RW-1:0] sn;
    logic [DW-1:0] sb;
    logic [2:0]    dm;
    logic [RW-1:0] dn;
    logic [DW-1:0] db;
    logic [DW-1:0] ofs;
    logic [LW-1:0] lit;
    logic          byt;
    logic [DW-1:0] sea;
    logic          sreg;
    logic          swb;
    logic [DW-1:0] swbv;
    logic [DW-1:0] dea;
    logic          dreg;
    logic          dwb;
    logic [DW-1:0] dwbv;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{3'd0, 4'd1,  16'h1234, 3'd1, 4'd2,  16'h0800, 16'h0000, 10'h000, 1'b0,
      16'h0000, 1'b1, 1'b0, 16'h0000, 16'h0800, 1'b0, 1'b0, 16'h0000},
    '{3'd3, 4'd3,  16'h1000, 3'd2, 4'd4,  16'h2000, 16'h0000, 10'h000, 1'b0,
      16'h1000, 1'b0, 1'b1, 16'h1002, 16'h2000, 1'b0, 1'b1, 16'h1FFE},
    '{3'd3, 4'd3,  16'h1000, 3'd2, 4'd4,  16'h2000, 16'h0000, 10'h000, 1'b1,
      16'h1000, 1'b0, 1'b1, 16'h1001, 16'h2000, 1'b0, 1'b1, 16'h1FFF},
    '{3'd4, 4'd5,  16'h0100, 3'd5, 4'd6,  16'h0200, 16'h0000, 10'h000, 1'b0,
      16'h00FE, 1'b0, 1'b1, 16'h00FE, 16'h0202, 1'b0, 1'b1, 16'h0202},
    '{3'd5, 4'd7,  16'h00FF, 3'd4, 4'd8,  16'h0001, 16'h0000, 10'h000, 1'b1,
      16'h0100, 1'b0, 1'b1, 16'h0100, 16'h0000, 1'b0, 1'b1, 16'h0000},
    '{3'd6, 4'd9,  16'h4000, 3'd6, 4'd10, 16'h8000, 16'h0010, 10'h000, 1'b0,
      16'h4010, 1'b0, 1'b0, 16'h0000, 16'h8010, 1'b0, 1'b0, 16'h0000},
    '{3'd7, 4'd11, 16'h3000, 3'd7, 4'd12, 16'h0010, 16'h0000, 10'h1FF, 1'b0,
      16'h31FF, 1'b0, 1'b0, 16'h0000, 16'h020F, 1'b0, 1'b0, 16'h0000},
    '{3'd7, 4'd13, 16'h3000, 3'd7, 4'd14, 16'h0008, 16'h0000, 10'h3F0, 1'b0,
      16'h2FF0, 1'b0, 1'b0, 16'h0000, 16'hFFF8, 1'b0, 1'b0, 16'h0000},
    '{3'd3, 4'd15, 16'hFFFF, 3'd4, 4'd0,  16'h0000, 16'h0000, 10'h000, 1'b0,
      16'hFFFF, 1'b0, 1'b1, 16'h0001, 16'hFFFE, 1'b0, 1'b1, 16'hFFFE},
    '{3'd6, 4'd1,  16'hFFF0, 3'd0, 4'd2,  16'h5555, 16'h0020, 10'h000, 1'b0,
      16'h0010, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 1'b0, 16'h0000}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          byt = 1'b0;
  logic [DW-1:0] ofs = '0;
  logic [LW-1:0] lit = '0;
  logic [2:0]    sm = '0, dm = '0;
  logic [RW-1:0] sn = '0, dn = '0;
  logic [DW-1:0] sb = '0, db = '0;
  logic          vld, sreg, swb, dreg, dwb;
  logic [DW-1:0] sea, swbv, dea, dwbv;
  logic [RW-1:0] swbn, dwbn;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  agu_ea_gen #(.DW(DW), .RW(RW), .LW(LW)) u0 (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .byte_i (byt),
    .ofs_i (ofs), .lit_i (lit),
    .src_mode_i (sm), .src_num_i (sn), .src_base_i (sb),
    .dst_mode_i (dm), .dst_num_i (dn), .dst_base_i (db),
    .out_valid_o (vld),
    .src_ea_o (sea), .src_reg_o (sreg), .src_wb_en_o (swb),
    .src_wb_num_o (swbn), .src_wb_val_o (swbv),
    .dst_ea_o (dea), .dst_reg_o (dreg), .dst_wb_en_o (dwb),
    .dst_wb_num_o (dwbn), .dst_wb_val_o (dwbv)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] m, input logic b);
    if (b && m >= 3'd2 && m <= 3'd5) return "R7";
    case (m)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2, 3'd3: return "R5";
      3'd4, 3'd5: return "R6";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic drive(input logic [2:0] s_m, input logic [RW-1:0] s_n, input logic [DW-1:0] s_b,
                       input logic [2:0] d_m, input logic [RW-1:0] d_n, input logic [DW-1:0] d_b,
                       input logic [DW-1:0] o, input logic [LW-1:0] l, input logic b, input logic r);
    sm = s_m; sn = s_n; sb = s_b; dm = d_m; dn = d_n; db = d_b;
    ofs = o; lit = l; byt = b; req = r;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: outputs zero while in reset
    #20;
    chk("R1 valid", 32'(vld), 0);
    chk("R1 src_ea", 32'(sea), 0);
    chk("R1 dst_wb_en", 32'(dwb), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i].sm, VECS[i].sn, VECS[i].sb, VECS[i].dm, VECS[i].dn, VECS[i].db,
            VECS[i].ofs, VECS[i].lit, VECS[i].byt, 1'b1);
      @(posedge clk);
      @(negedge clk);
      begin
        string st, dt;
        st = tag_of(VECS[i].sm, VECS[i].byt);
        dt = tag_of(VECS[i].dm, VECS[i].byt);
        chk("R2 valid", 32'(vld), 1);
        chk({st, " src_ea"}, 32'(sea), 32'(VECS[i].sea));
        chk({st, " src_reg"}, 32'(sreg), 32'(VECS[i].sreg));
        chk({st, " src_wb_en"}, 32'(swb), 32'(VECS[i].swb));
        chk({st, " src_wb_val"}, 32'(swbv), 32'(VECS[i].swbv));
        chk({st, " src_wb_num"}, 32'(swbn), VECS[i].swb ? 32'(VECS[i].sn) : 0);
        chk({dt, " dst_ea"}, 32'(dea), 32'(VECS[i].dea));
        chk({dt, " dst_reg"}, 32'(dreg), 32'(VECS[i].dreg));
        chk({dt, " dst_wb_en"}, 32'(dwb), 32'(VECS[i].dwb));
        chk({dt, " dst_wb_val"}, 32'(dwbv), 32'(VECS[i].dwbv));
        chk({dt, " dst_wb_num"}, 32'(dwbn), VECS[i].dwb ? 32'(VECS[i].dn) : 0);
      end
    end

    // R2 / R12: modifying mode presented without req has no effect at the outputs
    @(negedge clk);
    drive(3'd3, 4'd3, 16'h1000, 3'd5, 4'd4, 16'h2000, '0, '0, 1'b0, 1'b0);
    @(posedge clk);
    @(negedge clk);
    chk("R2 idle valid", 32'(vld), 0);
    chk("R2 idle src_ea", 32'(sea), 0);
    chk("R12 idle src_wb_en", 32'(swb), 0);
    chk("R12 idle dst_wb_en", 32'(dwb), 0);
    chk("R12 idle dst_wb_val", 32'(dwbv), 0);

    // R10 / R11: independent paths, wrap at both ends of the address space
    drive(3'd3, 4'd9, 16'hFFFE, 3'd4, 4'd6, 16'h0001, '0, '0, 1'b0, 1'b1);
    @(posedge clk);
    @(negedge clk);
    chk("R11 src_wb_val wrap up", 32'(swbv), 32'h0000);
    chk("R11 dst_ea wrap down", 32'(dea), 32'hFFFF);
    chk("R10 src_wb_num", 32'(swbn), 9);
    chk("R10 dst_wb_num", 32'(dwbn), 6);

    // R1: asynchronous reset clears pending results
    drive(3'd5, 4'd2, 16'h0040, 3'd1, 4'd3, 16'h0050, '0, '0, 1'b0, 1'b1);
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    chk("R1 mid reset valid", 32'(vld), 0);
    chk("R1 mid reset src_ea", 32'(sea), 0);
    chk("R1 mid reset src_wb_en", 32'(swb), 0);
    chk("R1 mid reset dst_ea", 32'(dea), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule